// File: doc/BRIEF.md
# Parallel I/O Port with Strobe Handshake

The block is a CPU-side controller for an 8-bit parallel port. A small register bus lets software choose an operating mode, set the direction of each pin, read the pins and load an output value. In software mode the CPU reads the pins as they are at the moment of the read and drives them straight from the output register. In handshake mode an external device presents data and raises an active-low strobe. The block latches the data, marks the input register full on a status bit, drives an input-full pin and, when enabled, raises an interrupt. Software empties the register by writing 0 to that status bit. The output side mirrors this. A CPU write of the output register sets an output-full pin, and an active-low acknowledge pulse from the device clears it.

Registers, at bus offsets: 0 command, 1 status, 2 direction, 3 input data, 4 output data. All are 8 bits wide and reset to 0. Command bits [1:0] hold the mode: 1x is software mode, 01 is handshake mode and 00 is idle. Command bit 2 enables strobe input and command bit 3 enables the input-full interrupt. Status bit 0 is input full and status bit 1 is output full. Offsets with no register read as 0.

The input side is a two-state machine: IN_EMPTY goes to IN_FULL on an accepted strobe edge (transition CAPTURE), and IN_FULL goes back to IN_EMPTY on a software clear (transition RELEASE). The output side is a second two-state machine: OUT_EMPTY goes to OUT_FULL on an output write in handshake mode (transition LOAD), and OUT_FULL goes back to OUT_EMPTY on the end of an acknowledge pulse (transition DRAIN). If a LOAD and a DRAIN fall in the same cycle, LOAD wins. Strobe and acknowledge each pass through two synchronising flops. Their rising edges are the events the machines act on.

Top module: `pio_hs_port`

## Requirements
- R1: After reset all five registers read 0, and in_full, out_full, irq and pin_oe are 0.
- R2: When command bits [1:0] are 10 or 11 (software mode), a read of offset 3 returns the current pin_in value in the same cycle.
- R3: pin_oe equals the direction register and pin_out equals the output data register, bit by bit, in every mode.
- R4: In handshake mode (command bits [1:0] = 01) with command bit 2 set, a rising edge of strobe_n captures pin_in into the input data register. The same edge sets status bit 0 and in_full, three clock edges after strobe_n rises.
- R5: A strobe edge has no effect when command bit 2 is 0 or when the mode is not 01. Status bit 0 and in_full stay 0.
- R6: A strobe edge while status bit 0 is 1 is ignored, and the input data register keeps its earlier value.
- R7: irq is 1 exactly while status bit 0 is 1 and command bit 3 is 1.
- R8: A write to offset 1 with bit 0 = 0 clears status bit 0, in_full and irq on the next clock edge. A write with bit 0 = 1 leaves status bit 0 unchanged.
- R9: A write to offset 4 in handshake mode sets out_full and status bit 1. A rising edge of ack_n then clears them. A write to offset 4 in software mode leaves out_full at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Levels seen on the parallel pins |
| pin_out | output | 8 | Value driven on the parallel pins |
| pin_oe | output | 8 | Per-pin output enable |
| strobe_n | input | 1 | Active-low input strobe from the device |
| ack_n | input | 1 | Active-low acknowledge from the device |
| in_full | output | 1 | Input data register holds unread data |
| out_full | output | 1 | Output data register waits for acknowledge |
| irq | output | 1 | Input-full interrupt |

## Verification
A wrong input state shows on the in_full pin and on status bit 0 at once. It also shows three clock edges after the next strobe as an overwritten or a missing capture in the input data register, which the next read of offset 3 reveals. A stuck output state shows on out_full within four cycles of an acknowledge pulse. A wrong mode decode shows on the first read of offset 3, which returns latched data where live pins were expected or the reverse.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_IBUF = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_OBUF = 3'd4;

    localparam int unsigned CMD_IEN  = 2;
    localparam int unsigned CMD_IRQE = 3;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_HAND = 2'b01,
        MODE_SWA  = 2'b10,
        MODE_SWB  = 2'b11
    } mode_e;

    typedef enum logic {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_state_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{IDLE_LVL}};
        else        chain_q <= {chain_q[CHAIN_W-2:0], din};
    end

    assign rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/pio_in_fsm.sv
module pio_in_fsm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              strobe_rise,
    input  logic              release_req,
    input  logic [DATA_W-1:0] pins,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    import pio_pkg::*;

    in_state_e state_q, state_d;
    logic      capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IN_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            IN_EMPTY: if (accept && strobe_rise) begin
                state_d = IN_FULL;
                capture = 1'b1;
            end
            IN_FULL:  if (release_req) state_d = IN_EMPTY;
            default:  state_d = IN_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data <= '0;
        else if (capture) data <= pins;
    end

    assign full = (state_q == IN_FULL);
endmodule

// File: rtl/pio_out_fsm.sv
module pio_out_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic ack_rise,
    output logic full
);
    import pio_pkg::*;

    out_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (load) state_d = OUT_FULL;
            OUT_FULL:  if (ack_rise && !load) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    assign full = (state_q == OUT_FULL);
endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [pio_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [DATA_W-1:0]          pin_in,
    output logic [DATA_W-1:0]          pin_out,
    output logic [DATA_W-1:0]          pin_oe,
    input  logic                       strobe_n,
    input  logic                       ack_n,
    output logic                       in_full,
    output logic                       out_full,
    output logic                       irq
);
    import pio_pkg::*;

    localparam int unsigned STAT_PAD = DATA_W - 2;

    logic [DATA_W-1:0] cmd_q, dir_q, obuf_q, ibuf;
    mode_e             mode;
    logic              wr_cmd, wr_stat, wr_dir, wr_obuf;
    logic              stb_rise, ack_rise, sw_mode, hs_mode;

    assign wr_cmd  = bus_sel && bus_wr && (bus_addr == OFS_CMD);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    assign wr_dir  = bus_sel && bus_wr && (bus_addr == OFS_DIR);
    assign wr_obuf = bus_sel && bus_wr && (bus_addr == OFS_OBUF);

    assign mode    = mode_e'(cmd_q[1:0]);
    assign sw_mode = (mode == MODE_SWA) || (mode == MODE_SWB);
    assign hs_mode = (mode == MODE_HAND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dir_q  <= '0;
            obuf_q <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= bus_wdata;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_obuf) obuf_q <= bus_wdata;
        end
    end

    pio_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) i_stb_sync (
        .clk(clk), .rst_n(rst_n), .din(strobe_n), .rise(stb_rise)
    );

    pio_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) i_ack_sync (
        .clk(clk), .rst_n(rst_n), .din(ack_n), .rise(ack_rise)
    );

    pio_in_fsm #(.DATA_W(DATA_W)) i_in_fsm (
        .clk(clk), .rst_n(rst_n),
        .accept(hs_mode && cmd_q[CMD_IEN]),
        .strobe_rise(stb_rise),
        .release_req(wr_stat && !bus_wdata[0]),
        .pins(pin_in),
        .full(in_full),
        .data(ibuf)
    );

    pio_out_fsm i_out_fsm (
        .clk(clk), .rst_n(rst_n),
        .load(wr_obuf && hs_mode),
        .ack_rise(ack_rise),
        .full(out_full)
    );

    assign irq     = in_full && cmd_q[CMD_IRQE];
    assign pin_out = obuf_q;
    assign pin_oe  = dir_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CMD:  bus_rdata = cmd_q;
            OFS_STAT: bus_rdata = {{STAT_PAD{1'b0}}, out_full, in_full};
            OFS_DIR:  bus_rdata = dir_q;
            OFS_IBUF: bus_rdata = sw_mode ? pin_in : ibuf;
            OFS_OBUF: bus_rdata = obuf_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pio_hs_port_chk.sv
module pio_hs_port_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic              wdata0,
    input logic [1:0]        mode_bits,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] ibuf,
    input logic              in_full,
    input logic              out_full,
    input logic              irq
);
    logic clr_wr;
    assign clr_wr = bus_sel && bus_wr && (bus_addr == 3'd1) && !wdata0;

    AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> in_full); // R7

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && !clr_wr) |=> in_full); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && clr_wr) |=> (!in_full && !irq)); // R8

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |=> $stable(ibuf)); // R6

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 3'd2) |=> $stable(pin_oe)); // R3

    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd4 && mode_bits == 2'b01) |=> out_full); // R9
endmodule

bind pio_hs_port pio_hs_port_chk #(.DATA_W(DATA_W)) i_pio_hs_port_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .wdata0(bus_wdata[0]), .mode_bits(cmd_q[1:0]),
    .pin_oe(pin_oe), .ibuf(ibuf), .in_full(in_full), .out_full(out_full),
    .irq(irq)
);

// File: tb/test_pio_hs_port.sv
`timescale 1ns/1ps
module test_pio_hs_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pin_in = '0, pin_out, pin_oe;
    logic       strobe_n = 1'b1, ack_n = 1'b1;
    logic       in_full, out_full, irq;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio_hs_port i_pio_hs_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .strobe_n(strobe_n), .ack_n(ack_n), .in_full(in_full),
        .out_full(out_full), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk);
        pin_in = d; strobe_n = 1'b0;
        repeat (3) @(negedge clk);
        strobe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reg", {24'd0, v}, 32'd0);
        end
        chk("R1 in_full", {31'd0, in_full}, 0);
        chk("R1 out_full", {31'd0, out_full}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 pin_oe", {24'd0, pin_oe}, 0);

        // R2 software mode live pin read, both encodings
        for (int m = 2; m < 4; m++) begin
            wr(3'd0, 8'(m));
            for (int p = 0; p < 256; p++) begin
                pin_in = 8'(p);
                rd(3'd3, v);
                chk("R2 live read", {24'd0, v}, p);
            end
        end

        // R3 direction and output value sweep
        wr(3'd4, 8'hA5);
        for (int d = 0; d < 256; d++) begin
            wr(3'd2, 8'(d));
            #1;
            chk("R3 pin_oe", {24'd0, pin_oe}, d);
            chk("R3 pin_out", {24'd0, pin_out}, 32'hA5);
        end
        wr(3'd2, 8'h00);

        // R9 software-mode output write leaves out_full clear
        wr(3'd4, 8'h3C);
        #1 chk("R9 sw no load", {31'd0, out_full}, 0);

        // R5 strobe ignored in software mode with enable set
        wr(3'd0, 8'b0000_0110);
        strobe(8'h11);
        chk("R5 sw mode ignore", {31'd0, in_full}, 0);
        // R5 strobe ignored in handshake mode with enable clear
        wr(3'd0, 8'b0000_1001);
        strobe(8'h22);
        rd(3'd1, v);
        chk("R5 ien off ignore", {24'd0, v}, 0);

        // R4 capture in handshake mode, irq enable on
        wr(3'd0, 8'b0000_1101);
        @(negedge clk);
        pin_in = 8'h5A; strobe_n = 1'b0;
        repeat (2) @(negedge clk);
        strobe_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 not yet full", {31'd0, in_full}, 0);
        @(negedge clk);
        chk("R4 full after 3 edges", {31'd0, in_full}, 1);
        chk("R7 irq on", {31'd0, irq}, 1);
        rd(3'd3, v);
        chk("R4 captured", {24'd0, v}, 32'h5A);
        rd(3'd1, v);
        chk("R4 status", {24'd0, v}, 1);

        // R6 overwrite protection
        strobe(8'hC3);
        rd(3'd3, v);
        chk("R6 kept", {24'd0, v}, 32'h5A);

        // R7 irq masked
        wr(3'd0, 8'b0000_0101);
        #1 chk("R7 irq masked", {31'd0, irq}, 0);
        wr(3'd0, 8'b0000_1101);

        // R8 writing 1 keeps, writing 0 clears
        wr(3'd1, 8'hFF);
        #1 chk("R8 write one keeps", {31'd0, in_full}, 1);
        wr(3'd1, 8'hFE);
        #1 chk("R8 cleared", {31'd0, in_full}, 0);
        chk("R8 irq cleared", {31'd0, irq}, 0);

        // R4 second capture after release
        strobe(8'h96);
        rd(3'd3, v);
        chk("R4 recapture", {24'd0, v}, 32'h96);
        wr(3'd1, 8'h00);

        // R9 output handshake
        wr(3'd4, 8'h77);
        #1 chk("R9 loaded", {31'd0, out_full}, 1);
        rd(3'd1, v);
        chk("R9 status bit1", {24'd0, v}, 2);
        @(negedge clk); ack_n = 1'b0;
        repeat (2) @(negedge clk); ack_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 drained", {31'd0, out_full}, 0);
        rd(3'd1, v);
        chk("R9 status clear", {24'd0, v}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule